// File: doc/BRIEF.md
# Rule-Chain Receive Frame Filer

The filer decides, for each received frame, whether it is kept or dropped and which receive queue and descriptor ring it belongs to. The frame arrives as a vector of property values, one slot per property ID, already extracted upstream. The block then walks a programmable rule table, one table position per clock. Each rule names a property ID, a value to compare for equality, a 6-bit queue index and four flags: cluster bracket, reject, AND-chain and interrupt request.

Rules do not form a flat first-match list. An AND-chained rule that matches passes the decision on to the following rule. One that misses skips ahead past the end of its chain. A cluster-bracket rule with AND set guards a group of rules: the walk enters the group only on a match and otherwise jumps past the group's closing rule. A bracket rule with AND clear closes the group. It can make a final decision, and when it misses the walk leaves the group. Clusters are one level deep. The table is written through a simple write port while the block is idle, and the number of live entries is an input.

A completed decision is reported with a one-cycle done strobe together with the accept flag, the queue index, the ring number and an interrupt pulse. A new frame is taken only through a ready/valid handshake while the block is idle.

Top module: `rule_chain_filer`

## Requirements
- R1: While reset is asserted, frm_ready_o is 1 and done_o, accept_o and gpi_o are 0.
- R2: A frame is taken on a clock edge with frm_valid_i and frm_ready_o both high. frm_ready_o stays low from the next cycle until done_o is raised, so no second frame starts during a walk.
- R3: A rule with cluster=0 and AND=0 whose property (the slot of frm_prop_i at bits pid*PROP_W upward) equals its stored value ends the walk. With reject=0 it accepts with the rule's queue index. On a miss the walk moves to the next rule.
- R4: A terminal matching rule with reject=1 drops the frame: accept_o=0 and queue_o, ring_o and gpi_o are all 0.
- R5: For an accepted frame ring_o is 0 when single_ring_i was high at the handshake. Otherwise it is queue_o modulo 8, which is the low 3 bits.
- R6: A rule with cluster=0 and AND=1 defers to the next rule on a match. On a miss, all rules up to and including the next rule with AND=0 are skipped. If that rule has cluster=1 and the walk is inside a cluster, the walk also leaves the cluster.
- R7: A rule with cluster=1 and AND=1, outside a cluster, enters a cluster on a match. On a miss, all rules up to and including the next rule with cluster=1 and AND=0 are skipped.
- R8: A rule with cluster=1 and AND=0 decides like R3 on a match. On a miss, the walk leaves the cluster and continues with the following rule.
- R9: Clusters do not nest. A cluster=1, AND=1 rule met inside a cluster acts as a cluster=0, AND=1 rule (R6).
- R10: If the walk passes the last live entry (index rule_cnt_i-1) without a final decision, the frame is rejected.
- R11: gpi_o pulses with done_o only for a terminal accept by a rule whose interrupt flag is set. A rule with AND=1 or reject=1 never raises it.
- R12: The reject flag has no effect on a rule with AND=1.
- R13: done_o is high for exactly one cycle, on the k-th rising edge after the handshake edge. Here k counts the table positions examined, skipped ones included, plus one when the walk runs off the table end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tbl_we_i | input | 1 | Rule table write enable |
| tbl_addr_i | input | IDX_W | Rule index written |
| tbl_pid_i | input | PID_W | Property ID of the rule |
| tbl_queue_i | input | 6 | Queue index of the rule |
| tbl_cle_i | input | 1 | Cluster bracket flag |
| tbl_rej_i | input | 1 | Reject flag |
| tbl_and_i | input | 1 | AND-chain flag |
| tbl_gpi_i | input | 1 | Interrupt request flag |
| tbl_val_i | input | PROP_W | Value compared with the property |
| rule_cnt_i | input | CNT_W | Number of live rules |
| single_ring_i | input | 1 | Send all accepted frames to ring 0 |
| frm_valid_i | input | 1 | Frame properties valid |
| frm_ready_o | output | 1 | Block idle, frame can be taken |
| frm_prop_i | input | NUM_PROP*PROP_W | Frame property values, slot per ID |
| done_o | output | 1 | Decision strobe |
| accept_o | output | 1 | Frame kept |
| queue_o | output | 6 | Queue index of accepted frame |
| ring_o | output | RING_W | Descriptor ring of accepted frame |
| gpi_o | output | 1 | Interrupt request pulse |

## Verification
The bench targets the skip paths. If a design ended an AND-chain skip one rule early or late, or carried a skip past the closing bracket, the wrong later rule would fire, giving a different queue and latency. A nested enter inside a cluster is set up so that treating it as a second cluster level skips the closing rule, which would file the frame to a different queue. Reject flags on chained rules, interrupt flags on rejecting or deferring rules and a walk off the table end are each arranged so that a wrong design changes accept, gpi or done timing. Frames are sent back to back with valid held high, so a design that starts early or strobes done twice produces an unexpected decision.

// File: rtl/filer_pkg.sv
package filer_pkg;

  localparam int QUEUE_W = 6;

  typedef struct packed {
    logic cle;
    logic rej;
    logic and_f;
    logic gpi;
  } rule_flags_t;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WALK     = 2'd1,
    ST_SKIP_AND = 2'd2,
    ST_SKIP_CLU = 2'd3
  } walk_state_e;

endpackage

// File: rtl/filer_rule_table.sv
module filer_rule_table
  import filer_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int PID_W  = 3,
  parameter int PROP_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   waddr_i,
  input  logic [PID_W-1:0]   wpid_i,
  input  logic [QUEUE_W-1:0] wqueue_i,
  input  rule_flags_t        wflags_i,
  input  logic [PROP_W-1:0]  wval_i,
  input  logic [IDX_W-1:0]   raddr_i,
  output logic [PID_W-1:0]   rpid_o,
  output logic [QUEUE_W-1:0] rqueue_o,
  output rule_flags_t        rflags_o,
  output logic [PROP_W-1:0]  rval_o
);

  logic [PID_W-1:0]   pid_q   [DEPTH];
  logic [QUEUE_W-1:0] queue_q [DEPTH];
  rule_flags_t        flags_q [DEPTH];
  logic [PROP_W-1:0]  val_q   [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic sel;
    assign sel = we_i && (waddr_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pid_q[e]   <= '0;
        queue_q[e] <= '0;
        flags_q[e] <= '0;
        val_q[e]   <= '0;
      end else if (sel) begin
        pid_q[e]   <= wpid_i;
        queue_q[e] <= wqueue_i;
        flags_q[e] <= wflags_i;
        val_q[e]   <= wval_i;
      end
    end
  end

  assign rpid_o   = pid_q[raddr_i];
  assign rqueue_o = queue_q[raddr_i];
  assign rflags_o = flags_q[raddr_i];
  assign rval_o   = val_q[raddr_i];

endmodule

// File: rtl/filer_match.sv
module filer_match #(
  parameter int NUM_PROP = 8,
  parameter int PROP_W   = 16,
  localparam int PID_W   = $clog2(NUM_PROP)
) (
  input  logic [NUM_PROP*PROP_W-1:0] props_i,
  input  logic [PID_W-1:0]           pid_i,
  input  logic [PROP_W-1:0]          val_i,
  output logic                       hit_o
);

  logic [PROP_W-1:0] prop_a [NUM_PROP];

  for (genvar g = 0; g < NUM_PROP; g++) begin : g_slot
    assign prop_a[g] = props_i[g*PROP_W +: PROP_W];
  end

  // exact equality against the slot selected by the rule
  always_comb begin
    hit_o = 1'b0;
    for (int k = 0; k < NUM_PROP; k++) begin
      if (pid_i == PID_W'(k)) hit_o = (prop_a[k] == val_i);
    end
  end

endmodule

// File: rtl/filer_walker.sv
module filer_walker
  import filer_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int NUM_RINGS = 8,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int RING_W   = $clog2(NUM_RINGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               single_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  rule_flags_t        flags_i,
  input  logic [QUEUE_W-1:0] queue_i,
  input  logic               hit_i,
  output logic [IDX_W-1:0]   ridx_o,
  output logic               ready_o,
  output logic               done_o,
  output logic               accept_o,
  output logic [QUEUE_W-1:0] queue_o,
  output logic [RING_W-1:0]  ring_o,
  output logic               gpi_o
);

  walk_state_e        state_q, state_d;
  logic [CNT_W-1:0]   idx_q, idx_d;
  logic [CNT_W-1:0]   cnt_q;
  logic               single_q;
  logic               clu_q, clu_d;

  logic               fin, fin_acc, fin_gpi;
  logic [QUEUE_W-1:0] fin_queue;
  logic [RING_W-1:0]  fin_ring;
  logic               in_range;
  logic               eff_cle;
  logic [CNT_W-1:0]   cnt_clamp;

  assign in_range  = idx_q < cnt_q;
  assign ridx_o    = idx_q[IDX_W-1:0];
  assign ready_o   = (state_q == ST_IDLE);
  assign cnt_clamp = (cnt_i > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : cnt_i;
  // an enter seen inside a cluster degrades to a plain AND rule
  assign eff_cle   = flags_i.cle && !(clu_q && flags_i.and_f);

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    clu_d     = clu_q;
    fin       = 1'b0;
    fin_acc   = 1'b0;
    fin_gpi   = 1'b0;
    fin_queue = '0;
    fin_ring  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_WALK;
          idx_d   = '0;
          clu_d   = 1'b0;
        end
      end
      ST_WALK: begin
        if (!in_range) begin
          fin = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
          unique case ({eff_cle, flags_i.and_f})
            2'b00: begin
              if (hit_i) begin
                fin     = 1'b1;
                fin_acc = !flags_i.rej;
              end
            end
            2'b01: begin
              if (!hit_i) state_d = ST_SKIP_AND;
            end
            2'b11: begin
              if (hit_i) clu_d = 1'b1;
              else       state_d = ST_SKIP_CLU;
            end
            default: begin
              if (hit_i) begin
                fin     = 1'b1;
                fin_acc = !flags_i.rej;
              end else begin
                clu_d = 1'b0;
              end
            end
          endcase
        end
      end
      ST_SKIP_AND: begin
        if (!in_range) begin
          fin = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
          if (!flags_i.and_f) begin
            state_d = ST_WALK;
            if (flags_i.cle) clu_d = 1'b0;
          end
        end
      end
      default: begin
        if (!in_range) begin
          fin = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
          if (flags_i.cle && !flags_i.and_f) state_d = ST_WALK;
        end
      end
    endcase
    if (fin) begin
      state_d = ST_IDLE;
      if (fin_acc) begin
        fin_queue = queue_i;
        fin_ring  = single_q ? '0 : queue_i[RING_W-1:0];
        fin_gpi   = flags_i.gpi;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      cnt_q    <= '0;
      single_q <= 1'b0;
      clu_q    <= 1'b0;
      done_o   <= 1'b0;
      accept_o <= 1'b0;
      queue_o  <= '0;
      ring_o   <= '0;
      gpi_o    <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      clu_q    <= clu_d;
      done_o   <= fin;
      accept_o <= fin_acc;
      queue_o  <= fin_queue;
      ring_o   <= fin_ring;
      gpi_o    <= fin_gpi;
      if (state_q == ST_IDLE && start_i) begin
        cnt_q    <= cnt_clamp;
        single_q <= single_i;
      end
    end
  end

  a_r13_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_idx_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> (idx_q <= cnt_q));

  a_r4_reject_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !accept_o) |-> (queue_o == '0 && ring_o == '0 && !gpi_o));

  a_r11_gpi_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpi_o |-> (done_o && accept_o));

endmodule

// File: rtl/rule_chain_filer.sv
module rule_chain_filer
  import filer_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int NUM_PROP  = 8,
  parameter int PROP_W    = 16,
  parameter int NUM_RINGS = 8,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int PID_W    = $clog2(NUM_PROP),
  localparam int RING_W   = $clog2(NUM_RINGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tbl_we_i,
  input  logic [IDX_W-1:0]           tbl_addr_i,
  input  logic [PID_W-1:0]           tbl_pid_i,
  input  logic [QUEUE_W-1:0]         tbl_queue_i,
  input  logic                       tbl_cle_i,
  input  logic                       tbl_rej_i,
  input  logic                       tbl_and_i,
  input  logic                       tbl_gpi_i,
  input  logic [PROP_W-1:0]          tbl_val_i,
  input  logic [CNT_W-1:0]           rule_cnt_i,
  input  logic                       single_ring_i,
  input  logic                       frm_valid_i,
  output logic                       frm_ready_o,
  input  logic [NUM_PROP*PROP_W-1:0] frm_prop_i,
  output logic                       done_o,
  output logic                       accept_o,
  output logic [QUEUE_W-1:0]         queue_o,
  output logic [RING_W-1:0]          ring_o,
  output logic                       gpi_o
);

  logic [NUM_PROP*PROP_W-1:0] prop_q;
  logic                       start;
  logic [IDX_W-1:0]           ridx;
  logic [PID_W-1:0]           rpid;
  logic [QUEUE_W-1:0]         rqueue;
  rule_flags_t                rflags, wflags;
  logic [PROP_W-1:0]          rval;
  logic                       hit;

  assign start  = frm_valid_i && frm_ready_o;
  assign wflags = '{cle: tbl_cle_i, rej: tbl_rej_i, and_f: tbl_and_i, gpi: tbl_gpi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prop_q <= '0;
    else if (start) prop_q <= frm_prop_i;
  end

  filer_rule_table #(
    .DEPTH (DEPTH),
    .PID_W (PID_W),
    .PROP_W(PROP_W)
  ) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wpid_i  (tbl_pid_i),
    .wqueue_i(tbl_queue_i),
    .wflags_i(wflags),
    .wval_i  (tbl_val_i),
    .raddr_i (ridx),
    .rpid_o  (rpid),
    .rqueue_o(rqueue),
    .rflags_o(rflags),
    .rval_o  (rval)
  );

  filer_match #(
    .NUM_PROP(NUM_PROP),
    .PROP_W  (PROP_W)
  ) u_match (
    .props_i(prop_q),
    .pid_i  (rpid),
    .val_i  (rval),
    .hit_o  (hit)
  );

  filer_walker #(
    .DEPTH    (DEPTH),
    .NUM_RINGS(NUM_RINGS)
  ) u_walker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .single_i(single_ring_i),
    .cnt_i   (rule_cnt_i),
    .flags_i (rflags),
    .queue_i (rqueue),
    .hit_i   (hit),
    .ridx_o  (ridx),
    .ready_o (frm_ready_o),
    .done_o  (done_o),
    .accept_o(accept_o),
    .queue_o (queue_o),
    .ring_o  (ring_o),
    .gpi_o   (gpi_o)
  );

  a_r2_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_i && frm_ready_o) |=> !frm_ready_o);

  a_r5_ring_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && accept_o) |-> (ring_o == '0 || ring_o == queue_o[RING_W-1:0]));

endmodule

// File: tb/rule_chain_filer_bench.sv
module rule_chain_filer_bench;

  localparam int DEPTH = 16, NUM_PROP = 8, PROP_W = 16, NUM_RINGS = 8;
  localparam int IDX_W = $clog2(DEPTH), CNT_W = $clog2(DEPTH + 1);
  localparam int PID_W = $clog2(NUM_PROP), RING_W = $clog2(NUM_RINGS);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tbl_we_i = 1'b0;
  logic [IDX_W-1:0] tbl_addr_i = '0;
  logic [PID_W-1:0] tbl_pid_i = '0;
  logic [5:0] tbl_queue_i = '0;
  logic tbl_cle_i = 1'b0, tbl_rej_i = 1'b0, tbl_and_i = 1'b0, tbl_gpi_i = 1'b0;
  logic [PROP_W-1:0] tbl_val_i = '0;
  logic [CNT_W-1:0] rule_cnt_i = '0;
  logic single_ring_i = 1'b0, frm_valid_i = 1'b0;
  logic [NUM_PROP*PROP_W-1:0] frm_prop_i = '0;
  logic frm_ready_o, done_o, accept_o, gpi_o;
  logic [5:0] queue_o;
  logic [RING_W-1:0] ring_o;

  always #2.5 clk = ~clk;

  rule_chain_filer u_rule_chain_filer (
    .clk_i(clk), .rst_ni(rst_ni),
    .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i), .tbl_pid_i(tbl_pid_i),
    .tbl_queue_i(tbl_queue_i), .tbl_cle_i(tbl_cle_i), .tbl_rej_i(tbl_rej_i),
    .tbl_and_i(tbl_and_i), .tbl_gpi_i(tbl_gpi_i), .tbl_val_i(tbl_val_i),
    .rule_cnt_i(rule_cnt_i), .single_ring_i(single_ring_i),
    .frm_valid_i(frm_valid_i), .frm_ready_o(frm_ready_o), .frm_prop_i(frm_prop_i),
    .done_o(done_o), .accept_o(accept_o), .queue_o(queue_o), .ring_o(ring_o),
    .gpi_o(gpi_o)
  );

  typedef struct {
    bit    acc;
    int    queue;
    int    ring;
    bit    gpi;
    int    lat;
    int    start;
    string tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pop and compare on each decision strobe
  always @(negedge clk) begin
    if (rst_ni && done_o) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2", "unexpected decision", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(accept_o == e.acc, e.tag, "accept", int'(accept_o), int'(e.acc));
        check(int'(queue_o) == e.queue, e.tag, "queue", int'(queue_o), e.queue);
        check(int'(ring_o) == e.ring, e.tag, "ring", int'(ring_o), e.ring);
        check(gpi_o == e.gpi, e.tag, "gpi", int'(gpi_o), int'(e.gpi));
        check(cyc - e.start == e.lat, "R13", {e.tag, " latency"}, cyc - e.start, e.lat);
      end
    end
  end

  task automatic wr_rule(input int idx, input int pid, input int q, input bit cle,
                         input bit rej, input bit andf, input bit gpi, input int val);
    @(negedge clk);
    tbl_we_i = 1'b1; tbl_addr_i = IDX_W'(idx); tbl_pid_i = PID_W'(pid);
    tbl_queue_i = 6'(q); tbl_cle_i = cle; tbl_rej_i = rej; tbl_and_i = andf;
    tbl_gpi_i = gpi; tbl_val_i = PROP_W'(val);
    @(negedge clk);
    tbl_we_i = 1'b0;
  endtask

  function automatic logic [NUM_PROP*PROP_W-1:0] pk(input int p0, p1, p2, p3,
                                                    input int p4 = 16'hFFFF);
    logic [NUM_PROP*PROP_W-1:0] v;
    v = {NUM_PROP*PROP_W{1'b1}};
    v[0*PROP_W +: PROP_W] = PROP_W'(p0);
    v[1*PROP_W +: PROP_W] = PROP_W'(p1);
    v[2*PROP_W +: PROP_W] = PROP_W'(p2);
    v[3*PROP_W +: PROP_W] = PROP_W'(p3);
    v[4*PROP_W +: PROP_W] = PROP_W'(p4);
    return v;
  endfunction

  // driver: hand over one frame, push its expected result
  task automatic send(input logic [NUM_PROP*PROP_W-1:0] pv, input bit single,
                      input bit acc, input int q, input int ring, input bit gpi,
                      input int lat, input string tag, input bit hold = 1'b0);
    exp_t e;
    @(negedge clk);
    while (!frm_ready_o) @(negedge clk);
    frm_valid_i = 1'b1; frm_prop_i = pv; single_ring_i = single;
    @(posedge clk);
    #1;
    e.acc = acc; e.queue = q; e.ring = ring; e.gpi = gpi;
    e.lat = lat; e.start = cyc; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    check(!frm_ready_o, "R2", "ready during walk", int'(frm_ready_o), 0);
    if (!hold) frm_valid_i = 1'b0;
  endtask

  task automatic drain;
    while (sb.size() != 0) @(negedge clk);
    frm_valid_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(frm_ready_o == 1'b1, "R1", "ready in reset", int'(frm_ready_o), 1);
    check(done_o == 1'b0, "R1", "done in reset", int'(done_o), 0);
    check(accept_o == 1'b0 && gpi_o == 1'b0, "R1", "accept/gpi in reset",
          int'(accept_o | gpi_o), 0);
    rst_ni = 1'b1;

    // R3, R5, R10: plain rules
    wr_rule(0, 1, 5, 0, 0, 0, 0, 16'h11);
    wr_rule(1, 2, 9, 0, 0, 0, 0, 16'h22);
    rule_cnt_i = 2;
    send(pk(0, 16'h11, 0, 0), 0, 1, 5, 5, 0, 1, "R3");
    send(pk(0, 16'h99, 16'h22, 0), 0, 1, 9, 1, 0, 2, "R3_R5");
    send(pk(0, 16'h99, 16'h22, 0), 1, 1, 9, 0, 0, 2, "R5");
    send(pk(0, 16'h98, 16'h23, 0), 0, 0, 0, 0, 0, 3, "R10");
    drain();

    // R4: matching reject rule ahead of a matching accept rule
    wr_rule(0, 0, 7, 0, 1, 0, 1, 16'hAA);
    wr_rule(1, 0, 3, 0, 0, 0, 0, 16'hAA);
    send(pk(16'hAA, 0, 0, 0), 0, 0, 0, 0, 0, 1, "R4_R11");
    drain();

    // R6, R12, R11: AND chain, reject on chained rule ignored, gpi on deferring rule
    wr_rule(0, 1, 50, 0, 0, 1, 1, 16'h1);
    wr_rule(1, 2, 51, 0, 1, 1, 0, 16'h2);
    wr_rule(2, 3, 12, 0, 0, 0, 0, 16'h3);
    wr_rule(3, 0, 20, 0, 0, 0, 0, 16'h7);
    rule_cnt_i = 4;
    send(pk(7, 1, 2, 3), 0, 1, 12, 4, 0, 3, "R12_R6", 1'b1);
    send(pk(7, 9, 2, 3), 0, 1, 20, 4, 0, 4, "R6", 1'b1);
    send(pk(7, 1, 9, 3), 0, 1, 20, 4, 0, 4, "R6");
    drain();

    // R7, R8, R11: one cluster
    wr_rule(0, 0, 60, 1, 0, 1, 1, 16'h10);
    wr_rule(1, 1, 33, 0, 0, 0, 1, 16'h21);
    wr_rule(2, 2, 34, 1, 0, 0, 0, 16'h32);
    wr_rule(3, 3, 35, 0, 0, 0, 0, 16'h43);
    send(pk(16'h10, 16'h21, 0, 0), 0, 1, 33, 1, 1, 2, "R11_R7", 1'b1);
    send(pk(16'h10, 16'h21, 0, 0), 1, 1, 33, 0, 1, 2, "R5_R11", 1'b1);
    send(pk(16'h10, 0, 16'h32, 0), 0, 1, 34, 2, 0, 3, "R8", 1'b1);
    send(pk(16'h10, 0, 0, 16'h43), 0, 1, 35, 3, 0, 4, "R8", 1'b1);
    send(pk(0, 16'h21, 16'h32, 16'h43), 0, 1, 35, 3, 0, 4, "R7", 1'b1);
    send(pk(0, 16'h21, 16'h32, 0), 0, 0, 0, 0, 0, 5, "R7_R10");
    drain();

    // R9: enter attempt inside cluster acts as AND rule
    wr_rule(0, 0, 61, 1, 0, 1, 0, 16'h1);
    wr_rule(1, 1, 62, 1, 0, 1, 0, 16'h2);
    wr_rule(2, 2, 40, 0, 0, 0, 0, 16'h3);
    wr_rule(3, 3, 41, 1, 0, 0, 0, 16'h4);
    wr_rule(4, 4, 42, 0, 0, 0, 0, 16'h5);
    rule_cnt_i = 5;
    send(pk(1, 9, 3, 4, 5), 0, 1, 41, 1, 0, 4, "R9");
    send(pk(1, 2, 3, 4, 5), 0, 1, 40, 0, 0, 3, "R9");
    drain();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule